// File: doc/BRIEF.md
# Multiplexed-bus register file interface

This block is the slave side of an 8-bit microcontroller port on which address and data take turns on the same wires. The host puts an address byte on the bus and pulses an address strobe low. It then puts a data byte on the bus and pulses a write strobe low. Both strobes are brought into the system clock domain and acted on at their falling edges. The address byte is not a flat index. It is a set of bit fields. One bit gates all access, one picks the mode registers, and the others choose acquisition or display, horizontal or vertical, and a register inside that group.

The stored bytes feed the timing generators as ready-made values. Start and stop positions are 9 bits wide. Each takes its low byte from its own register and its top bit from a shared register that the host loads separately. Two-bit fine delays and a few configuration flags are unpacked the same way.

The host can also read one status byte. An address with the read bit set arms a one-shot output mode. For the next address/data cycle only, the write strobe acts as an active-low read strobe, and the block drives the current 100 Hz field identifier onto the bus.

Top module: `mbus_regfile`

## Requirements
- R1: Both strobes pass through a two-flop synchronizer, and only their falling edges are used. The address is latched at the address strobe's falling edge. A falling edge on the write strobe stores the bus byte into the register named by the most recent address, and the output shows it within four clock cycles. A second data phase with no new address writes to the same register, even if the bus held another value while the strobes were idle.
- R2: An address whose bit 6 (operate) is 0 selects nothing, and the data phase that follows it writes no register.
- R3: When bit 6 and bit 5 are both 1, the mode registers are addressed. Address bit 0 picks mode register 0 (0x60) or mode register 1 (0x61), and bits 4:1 are ignored.
- R4: When bits 6:5 are 10 and bits 4:3 are 00 (display vertical, 0x40–0x46), indices 0–5 hold the low bytes of six 9-bit values. Index 6 holds their top bits: bit k is the MSB of value k.
- R5: When bits 4:3 are 01 (display horizontal, 0x48–0x4F), indices 0–5 hold the low bytes of six 9-bit values and index 6 holds their MSBs (bit k for value k). Index 7 holds three 2-bit fine delays: bits [2k+1:2k] belong to the start/stop pair k (values 2k and 2k+1).
- R6: When bits 4:3 are 10 (acquisition vertical, 0x50–0x52), indices 0 and 1 hold two low bytes and index 2 holds their MSBs in bits 0 and 1. When bits 4:3 are 11 (acquisition horizontal, 0x58–0x5C):
  - indices 0 and 1 are 8-bit clamp start and stop;
  - indices 2 and 3 are the low bytes of two 9-bit values;
  - index 4 holds the MSBs of those two values in bits 1:0, a 2-bit fine delay in bits 3:2 and three configuration flags in bits 6:4.
- R7: Indices beyond a group's last register (0x47, 0x53–0x57, 0x5D–0x5F) are ignored, and no output changes.
- R8: An address with bit 7 set writes nothing, and its own data phase is ignored. It arms a read. The next address phase also writes nothing and opens a read cycle. While the write strobe is low during that cycle, the output enable is high and the bus carries the field identifier in bit 0, with bits 7:1 zero.
- R9: The read cycle ends when the write strobe rises. The next address/data cycle is an ordinary write, and the output enable stays low during it.
- R10: Outside a read cycle, the output enable is low and the output bus is all zeros.
- R11: After reset, every register and output value is zero, the output enable is low and no read is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| as_n | input | 1 | Address strobe from host, falling edge latches the address |
| ws_n | input | 1 | Write strobe from host; read strobe during a read cycle |
| bus_i | input | 8 | Shared address/data bus from host |
| field_i | input | 1 | Current 100 Hz field identifier for readback |
| bus_o | output | 8 | Readback byte driven to the host |
| bus_oe | output | 1 | Output enable for bus_o |
| mode0_o | output | 8 | Mode register 0 |
| mode1_o | output | 8 | Mode register 1 |
| dv_val_o | output | 54 | Display vertical values, value k at [9k+8:9k] |
| dh_val_o | output | 54 | Display horizontal values, value k at [9k+8:9k] |
| dh_dly_o | output | 6 | Display horizontal fine delays, pair k at [2k+1:2k] |
| av_val_o | output | 18 | Acquisition vertical values, value k at [9k+8:9k] |
| ah_clamp_o | output | 16 | Clamp stop [15:8] and clamp start [7:0] |
| ah_val_o | output | 18 | Acquisition horizontal values, value k at [9k+8:9k] |
| ah_dly_o | output | 2 | Acquisition horizontal fine delay |
| ah_cfg_o | output | 3 | Acquisition configuration flags |

## Verification
The assertions check on every cycle that:
- each register group holds its contents unless a write is decoded for it;
- a synchronized falling edge never lasts two cycles;
- an armed read and an open read cycle never coexist;
- the bus is all zeros whenever output is disabled, and carries only bit 0 when enabled.

Only the bench's scenarios can show the address decoding. Two full sweeps over every write address with distinct data patterns compare all unpacked values against a model of the map. These sweeps also show that gaps and operate-less addresses leave every output untouched. The one-shot read, the reuse of a latched address and the return to ordinary writes after a read are shown by directed strobe sequences.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    localparam int BYTE_W = 8;
    localparam int VAL_W  = 9;
    localparam int IDX_W  = 3;

    // address bit positions
    localparam int A_RD   = 7;
    localparam int A_OP   = 6;
    localparam int A_MODE = 5;
    localparam int A_ACQ  = 4;
    localparam int A_HOR  = 3;

    // register counts per group
    localparam int DV_DEPTH   = 7;
    localparam int DH_DEPTH   = 8;
    localparam int AV_DEPTH   = 3;
    localparam int AH_DEPTH   = 5;
    localparam int MODE_DEPTH = 2;

    // derived value counts and shared-register positions
    localparam int DV_VALS   = DV_DEPTH - 1;
    localparam int DH_VALS   = DH_DEPTH - 2;
    localparam int AV_VALS   = AV_DEPTH - 1;
    localparam int AH_VALS   = 2;
    localparam int DV_MSB_IX = DV_VALS;
    localparam int DH_MSB_IX = DH_VALS;
    localparam int DH_DLY_IX = DH_VALS + 1;
    localparam int AV_MSB_IX = AV_VALS;
    localparam int AH_LO_IX  = 2;
    localparam int AH_MSC_IX = 4;
    localparam int DLY_W     = 2;
    localparam int CFG_W     = 3;

    typedef enum logic [2:0] {
        GRP_NONE,
        GRP_DV,
        GRP_DH,
        GRP_AV,
        GRP_AH,
        GRP_MODE
    } grp_e;

    typedef struct packed {
        grp_e             grp;
        logic [IDX_W-1:0] idx;
    } sel_t;

    function automatic sel_t decode_addr(input logic [BYTE_W-1:0] a);
        sel_t s;
        s.grp = GRP_NONE;
        s.idx = a[IDX_W-1:0];
        if (!a[A_RD] && a[A_OP]) begin
            if (a[A_MODE]) begin
                s.grp = GRP_MODE;
                s.idx = {{(IDX_W-1){1'b0}}, a[0]};
            end else begin
                case ({a[A_ACQ], a[A_HOR]})
                    2'b00:   s.grp = GRP_DV;
                    2'b01:   s.grp = GRP_DH;
                    2'b10:   s.grp = GRP_AV;
                    default: s.grp = GRP_AH;
                endcase
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/mbus_strobe_sync.sv
module mbus_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic lvl_o,
    output logic fell_o,
    output logic rose_o
);

    typedef struct packed {
        logic [STAGES:0] sh;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[STAGES-1:0], strobe_n};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sh: '1};
        else        st_q <= st_d;
    end

    assign lvl_o  = st_q.sh[STAGES-1];
    assign fell_o = st_q.sh[STAGES] & ~st_q.sh[STAGES-1];
    assign rose_o = ~st_q.sh[STAGES] & st_q.sh[STAGES-1];

    // R1: a synchronized falling edge is a single-cycle event
    assert_edge_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fell_o |=> !fell_o);

endmodule

// File: rtl/mbus_reg_group.sv
module mbus_reg_group
    import mbus_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [BYTE_W-1:0]       wr_data,
    output logic [DEPTH*BYTE_W-1:0] regs_o
);

    typedef struct packed {
        logic [DEPTH-1:0][BYTE_W-1:0] mem;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_en && wr_idx == IDX_W'(i)) st_d.mem[i] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign regs_o = st_q.mem;

    // R7: contents only move when a write is decoded for this group
    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q.mem));

endmodule

// File: rtl/mbus_bus_ctrl.sv
module mbus_bus_ctrl
    import mbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_fell,
    input  logic              ws_fell,
    input  logic              ws_rose,
    input  logic              ws_lvl,
    input  logic [BYTE_W-1:0] bus_i,
    input  logic              field_i,
    output logic              wr_en,
    output grp_e              wr_grp,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] bus_o,
    output logic              bus_oe
);

    typedef struct packed {
        logic [BYTE_W-1:0] addr;
        logic              armed;
        logic              rd_cyc;
        logic              oe;
        logic [BYTE_W-1:0] dout;
    } st_t;

    st_t  st_d, st_q;
    sel_t sel;

    always_comb begin
        st_d = st_q;
        if (as_fell) begin
            if (st_q.armed) begin
                st_d.rd_cyc = 1'b1;
                st_d.armed  = 1'b0;
                st_d.addr   = '0;
            end else begin
                st_d.rd_cyc = 1'b0;
                st_d.addr   = bus_i;
                st_d.armed  = bus_i[A_RD];
            end
        end else if (ws_rose && st_q.rd_cyc) begin
            st_d.rd_cyc = 1'b0;
        end
        st_d.oe   = st_d.rd_cyc && !ws_lvl;
        st_d.dout = st_d.oe ? {{(BYTE_W-1){1'b0}}, field_i} : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        sel     = decode_addr(st_q.addr);
        wr_en   = ws_fell && !st_q.rd_cyc && (sel.grp != GRP_NONE);
        wr_grp  = sel.grp;
        wr_idx  = sel.idx;
        wr_data = bus_i;
    end

    assign bus_o  = st_q.dout;
    assign bus_oe = st_q.oe;

    // R9: an armed read and an open read cycle never overlap
    assert_read_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.rd_cyc && st_q.armed));

endmodule

// File: rtl/mbus_regfile.sv
module mbus_regfile
    import mbus_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      as_n,
    input  logic                      ws_n,
    input  logic [BYTE_W-1:0]         bus_i,
    input  logic                      field_i,
    output logic [BYTE_W-1:0]         bus_o,
    output logic                      bus_oe,
    output logic [BYTE_W-1:0]         mode0_o,
    output logic [BYTE_W-1:0]         mode1_o,
    output logic [DV_VALS*VAL_W-1:0]  dv_val_o,
    output logic [DH_VALS*VAL_W-1:0]  dh_val_o,
    output logic [DH_VALS-1:0]        dh_dly_o,
    output logic [AV_VALS*VAL_W-1:0]  av_val_o,
    output logic [2*BYTE_W-1:0]       ah_clamp_o,
    output logic [AH_VALS*VAL_W-1:0]  ah_val_o,
    output logic [DLY_W-1:0]          ah_dly_o,
    output logic [CFG_W-1:0]          ah_cfg_o
);

    logic as_lvl, as_fell, as_rose;
    logic ws_lvl, ws_fell, ws_rose;

    mbus_strobe_sync #(.STAGES(SYNC_STAGES)) u_as_sync (
        .clk(clk), .rst_n(rst_n), .strobe_n(as_n),
        .lvl_o(as_lvl), .fell_o(as_fell), .rose_o(as_rose)
    );

    mbus_strobe_sync #(.STAGES(SYNC_STAGES)) u_ws_sync (
        .clk(clk), .rst_n(rst_n), .strobe_n(ws_n),
        .lvl_o(ws_lvl), .fell_o(ws_fell), .rose_o(ws_rose)
    );

    logic              wr_en;
    grp_e              wr_grp;
    logic [IDX_W-1:0]  wr_idx;
    logic [BYTE_W-1:0] wr_data;

    mbus_bus_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .as_fell(as_fell), .ws_fell(ws_fell), .ws_rose(ws_rose), .ws_lvl(ws_lvl),
        .bus_i(bus_i), .field_i(field_i),
        .wr_en(wr_en), .wr_grp(wr_grp), .wr_idx(wr_idx), .wr_data(wr_data),
        .bus_o(bus_o), .bus_oe(bus_oe)
    );

    logic [DV_DEPTH*BYTE_W-1:0]   dv_regs;
    logic [DH_DEPTH*BYTE_W-1:0]   dh_regs;
    logic [AV_DEPTH*BYTE_W-1:0]   av_regs;
    logic [AH_DEPTH*BYTE_W-1:0]   ah_regs;
    logic [MODE_DEPTH*BYTE_W-1:0] md_regs;

    mbus_reg_group #(.DEPTH(DV_DEPTH)) u_grp_dv (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en && wr_grp == GRP_DV),
        .wr_idx(wr_idx), .wr_data(wr_data), .regs_o(dv_regs));

    mbus_reg_group #(.DEPTH(DH_DEPTH)) u_grp_dh (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en && wr_grp == GRP_DH),
        .wr_idx(wr_idx), .wr_data(wr_data), .regs_o(dh_regs));

    mbus_reg_group #(.DEPTH(AV_DEPTH)) u_grp_av (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en && wr_grp == GRP_AV),
        .wr_idx(wr_idx), .wr_data(wr_data), .regs_o(av_regs));

    mbus_reg_group #(.DEPTH(AH_DEPTH)) u_grp_ah (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en && wr_grp == GRP_AH),
        .wr_idx(wr_idx), .wr_data(wr_data), .regs_o(ah_regs));

    mbus_reg_group #(.DEPTH(MODE_DEPTH)) u_grp_md (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en && wr_grp == GRP_MODE),
        .wr_idx(wr_idx), .wr_data(wr_data), .regs_o(md_regs));

    assign mode0_o = md_regs[0 +: BYTE_W];
    assign mode1_o = md_regs[BYTE_W +: BYTE_W];

    // 9-bit values: low byte from its own register, MSB from the shared one
    for (genvar k = 0; k < DV_VALS; k++) begin : g_dv
        assign dv_val_o[k*VAL_W +: VAL_W] =
            {dv_regs[DV_MSB_IX*BYTE_W + k], dv_regs[k*BYTE_W +: BYTE_W]};
    end

    for (genvar k = 0; k < DH_VALS; k++) begin : g_dh
        assign dh_val_o[k*VAL_W +: VAL_W] =
            {dh_regs[DH_MSB_IX*BYTE_W + k], dh_regs[k*BYTE_W +: BYTE_W]};
    end

    assign dh_dly_o = dh_regs[DH_DLY_IX*BYTE_W +: DH_VALS];

    for (genvar k = 0; k < AV_VALS; k++) begin : g_av
        assign av_val_o[k*VAL_W +: VAL_W] =
            {av_regs[AV_MSB_IX*BYTE_W + k], av_regs[k*BYTE_W +: BYTE_W]};
    end

    assign ah_clamp_o = ah_regs[0 +: 2*BYTE_W];

    for (genvar k = 0; k < AH_VALS; k++) begin : g_ah
        assign ah_val_o[k*VAL_W +: VAL_W] =
            {ah_regs[AH_MSC_IX*BYTE_W + k], ah_regs[(AH_LO_IX+k)*BYTE_W +: BYTE_W]};
    end

    assign ah_dly_o = ah_regs[AH_MSC_IX*BYTE_W + AH_VALS +: DLY_W];
    assign ah_cfg_o = ah_regs[AH_MSC_IX*BYTE_W + AH_VALS + DLY_W +: CFG_W];

    logic unused_bits;
    assign unused_bits = ^{as_lvl, as_rose,
                           dv_regs[DV_DEPTH*BYTE_W-1 -: (BYTE_W-DV_VALS)],
                           dh_regs[(DH_MSB_IX+1)*BYTE_W-1 -: (BYTE_W-DH_VALS)],
                           dh_regs[DH_DEPTH*BYTE_W-1 -: (BYTE_W-DH_VALS)],
                           av_regs[AV_DEPTH*BYTE_W-1 -: (BYTE_W-AV_VALS)],
                           ah_regs[AH_DEPTH*BYTE_W-1 -: (BYTE_W-AH_VALS-DLY_W-CFG_W)]};

    // R10: nothing is driven onto the bus while output is disabled
    assert_idle_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> bus_o == '0);

    // R8: the readback byte uses only bit 0
    assert_readback_format_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> bus_o[BYTE_W-1:1] == '0);

endmodule

// File: tb/mbus_regfile_tb.sv
module mbus_regfile_tb;

    localparam int OUT_W = 187;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       as_n = 1'b1;
    logic       ws_n = 1'b1;
    logic [7:0] bus_i = 8'h00;
    logic       field = 1'b0;

    logic [7:0]  bus_o;
    logic        bus_oe;
    logic [7:0]  mode0_o, mode1_o;
    logic [53:0] dv_val_o, dh_val_o;
    logic [5:0]  dh_dly_o;
    logic [17:0] av_val_o, ah_val_o;
    logic [15:0] ah_clamp_o;
    logic [1:0]  ah_dly_o;
    logic [2:0]  ah_cfg_o;

    mbus_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .as_n(as_n), .ws_n(ws_n), .bus_i(bus_i),
        .field_i(field), .bus_o(bus_o), .bus_oe(bus_oe),
        .mode0_o(mode0_o), .mode1_o(mode1_o), .dv_val_o(dv_val_o),
        .dh_val_o(dh_val_o), .dh_dly_o(dh_dly_o), .av_val_o(av_val_o),
        .ah_clamp_o(ah_clamp_o), .ah_val_o(ah_val_o), .ah_dly_o(ah_dly_o),
        .ah_cfg_o(ah_cfg_o)
    );

    always #10 clk = ~clk;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    logic [7:0] m_dv [7];
    logic [7:0] m_dh [8];
    logic [7:0] m_av [3];
    logic [7:0] m_ah [5];
    logic [7:0] m_md [2];
    logic [7:0] last_addr;

    wire [OUT_W-1:0] act_vec = {mode1_o, mode0_o, dv_val_o, dh_val_o, dh_dly_o,
                                av_val_o, ah_clamp_o, ah_val_o, ah_dly_o, ah_cfg_o};

    function automatic logic [OUT_W-1:0] model_vec();
        logic [53:0] dv, dh;
        logic [17:0] av, ah;
        for (int k = 0; k < 6; k++) begin
            dv[k*9 +: 9] = {m_dv[6][k], m_dv[k]};
            dh[k*9 +: 9] = {m_dh[6][k], m_dh[k]};
        end
        for (int k = 0; k < 2; k++) begin
            av[k*9 +: 9] = {m_av[2][k], m_av[k]};
            ah[k*9 +: 9] = {m_ah[4][k], m_ah[2+k]};
        end
        return {m_md[1], m_md[0], dv, dh, m_dh[7][5:0], av, m_ah[1], m_ah[0],
                ah, m_ah[4][3:2], m_ah[4][6:4]};
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [7:0] d);
        int ix;
        ix = int'(a[2:0]);
        if (!a[7] && a[6]) begin
            if (a[5]) m_md[int'(a[0])] = d;
            else begin
                case (a[4:3])
                    2'b00:   if (ix < 7) m_dv[ix] = d;
                    2'b01:   m_dh[ix] = d;
                    2'b10:   if (ix < 3) m_av[ix] = d;
                    default: if (ix < 5) m_ah[ix] = d;
                endcase
            end
        end
    endtask

    function automatic string req_of(input logic [7:0] a);
        int ix;
        ix = int'(a[2:0]);
        if (a[7])  return "R8";
        if (!a[6]) return "R2";
        if (a[5])  return "R3";
        case (a[4:3])
            2'b00:   return (ix < 7) ? "R4" : "R7";
            2'b01:   return "R5";
            2'b10:   return (ix < 3) ? "R6" : "R7";
            default: return (ix < 5) ? "R6" : "R7";
        endcase
    endfunction

    task automatic check(input string req, input logic [OUT_W-1:0] act,
                         input logic [OUT_W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic addr_phase(input logic [7:0] a);
        bus_i = a;
        cyc(1);
        as_n = 1'b0;
        cyc(3);
        as_n = 1'b1;
    endtask

    task automatic data_phase(input logic [7:0] d, input string tag);
        bus_i = d;
        cyc(1);
        ws_n = 1'b0;
        model_write(last_addr, d);
        cyc(4);
        check(tag, act_vec, model_vec());
        check("R10", OUT_W'({bus_oe, bus_o}), OUT_W'(9'h000));
        ws_n = 1'b1;
        cyc(3);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d, input string tag);
        addr_phase(a);
        last_addr = a;
        data_phase(d, (tag == "") ? req_of(a) : tag);
    endtask

    task automatic read_cycle(input logic [7:0] arm, input logic [7:0] ra, input logic fld);
        bus_write(arm, 8'hFF, "R8");   // arming address: its data phase must be ignored
        addr_phase(ra);                // read-cycle address: must not write
        field = fld;
        bus_i = 8'hEE;
        cyc(1);
        ws_n = 1'b0;
        cyc(5);
        check("R8", OUT_W'({bus_oe, bus_o}), OUT_W'({1'b1, 7'b0, fld}));
        check("R8", act_vec, model_vec());
        ws_n = 1'b1;
        cyc(5);
        check("R9", OUT_W'({bus_oe, bus_o}), OUT_W'(9'h000));
        last_addr = 8'h00;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : main
        for (int i = 0; i < 7; i++) m_dv[i] = 8'h00;
        for (int i = 0; i < 8; i++) m_dh[i] = 8'h00;
        for (int i = 0; i < 3; i++) m_av[i] = 8'h00;
        for (int i = 0; i < 5; i++) m_ah[i] = 8'h00;
        m_md[0] = 8'h00;
        m_md[1] = 8'h00;
        last_addr = 8'h00;

        cyc(5);
        rst_n = 1'b1;
        cyc(3);
        // R11: reset state
        check("R11", act_vec, '0);
        check("R11", OUT_W'({bus_oe, bus_o}), OUT_W'(9'h000));
        // R11: no read armed after reset, a plain write goes through
        bus_write(8'h60, 8'h5A, "R11");

        // sweep every write address, first data pattern
        for (int a = 0; a < 128; a++) begin
            bus_write(8'(a), 8'(a) ^ 8'hA5, "");
        end

        // R1: address is latched at the strobe edge; a repeated data phase reuses it
        bus_write(8'h4A, 8'h11, "R1");
        bus_i = 8'h58;
        cyc(3);
        data_phase(8'h22, "R1");
        data_phase(8'h33, "R1");

        // R8, R9: one-shot readback with both field values
        read_cycle(8'h80, 8'h61, 1'b1);
        bus_write(8'h61, 8'h3C, "R9");
        read_cycle(8'hC5, 8'h40, 1'b0);
        bus_write(8'h40, 8'h7E, "R9");
        read_cycle(8'h80, 8'h80, 1'b1);
        bus_write(8'h4F, 8'h2D, "R9");

        // sweep every write address, second data pattern
        for (int a = 0; a < 128; a++) begin
            bus_write(8'(a), 8'((a * 37 + 11) & 8'hFF) ^ 8'h5C, "");
        end

        // boundary values: all-ones in the shared registers
        bus_write(8'h46, 8'hFF, "R4");
        bus_write(8'h4E, 8'hFF, "R5");
        bus_write(8'h4F, 8'hFF, "R5");
        bus_write(8'h52, 8'hFF, "R6");
        bus_write(8'h5C, 8'hFF, "R6");
        bus_write(8'h47, 8'h00, "R7");
        bus_write(8'h5F, 8'h00, "R7");
        bus_write(8'h3F, 8'h00, "R2");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule